// File: doc/BRIEF.md
# RTC Tick and Timer Interrupt Unit

This block turns a 32.768 kHz oscillator enable into a seconds count and collects four latched interrupt flags for a processor. A fifteen-stage binary prescaler, stepped once per oscillator enable, gives two periodic events. Its last stage rises once per second and advances a 32-bit seconds counter. Its ninth stage rises 64 times per second and sets a periodic tick flag. A 32-bit match register is compared with the seconds counter. When they agree, the match flag is raised at the following one-second edge.

The two timer flags record underflow events of external down counters. An underflow pulse only arms a flag. The flag becomes visible at the next falling edge of that timer's clock, which reaches the block as a single-cycle enable. A narrow write port loads the seconds counter and the match register, and gives each flag its own acknowledge address. A four-bit status word shows all flags at once. A standby input holds the tick flag low.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, `irq_status` is 4'b0000 and `rtc_seconds` is 0.
- R2: A timer flag sets on the first `tmr_clk_fall` enable of that timer that comes in a cycle strictly after the `tmr_uflow` pulse, and becomes visible in the next cycle. An enable in the same cycle as the underflow does not set it.
- R3: A timer flag is cleared only by a write to its acknowledge address: 2 for timer 1 and 3 for timer 2. The data value is ignored, and the flag clears in the cycle after the write. Without such a write, the flag holds.
- R4: When an acknowledge write and a new set event for the same flag occur in one cycle, the flag stays set.
- R5: A write to address 0 loads `rtc_seconds` with the write data and clears the prescaler. The first one-second edge comes on the 16384th oscillator enable after the clear, and later ones every 32768 enables. `rtc_seconds` advances by one in the second cycle after that enable.
- R6: The seconds counter wraps from 0xFFFFFFFF to 0. Outside a write to address 0, it changes only by an increment of one.
- R7: The match register is written at address 1. If a one-second edge finds `rtc_seconds` equal to the match register, the match flag (bit 2) sets together with that edge's increment, one second after the equality began. The match flag is acknowledged at address 4.
- R8: The tick flag (bit 3) sets on every rise of prescaler stage 9. The first rise comes on the 256th oscillator enable after a clear, and later ones every 512 enables. The flag is visible two cycles after that enable. It is acknowledged at address 5.
- R9: From the cycle after `standby` is high, the tick flag reads 0, and it does not set while `standby` stays high.
- R10: `irq_status` packs the flags as bit 0 timer 1, bit 1 timer 2, bit 2 match, bit 3 tick. Writes to addresses 6 and 7 change no flag and no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One-cycle enable per 32.768 kHz oscillator period |
| standby | input | 1 | Standby state; suppresses the tick flag |
| tmr_uflow | input | 2 | Underflow pulse per timer (bit 0 timer 1) |
| tmr_clk_fall | input | 2 | Falling-edge enable of each timer's clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 time, 1 match, 2..5 acknowledges) |
| wr_data | input | 32 | Write data |
| irq_status | output | 4 | Latched interrupt flags |
| rtc_seconds | output | 32 | Current seconds count |

## Verification
The assertions check the timer flags on every cycle. A timer flag may rise only after a falling-edge enable of its clock, it clears after an acknowledge that meets no edge, and it otherwise holds. The assertions also check on every cycle that the seconds count moves only by a load or a single increment, and that the tick flag stays low under standby. Some behaviour shows only in the bench's scenarios: the exact prescaler edge counts for the one-second and 64 Hz events, the one-second delay of the match flag across the wrap from 0xFFFFFFFF, the rule that an edge in the same cycle as an underflow is not counted, and a collision of an acknowledge with a set.

// File: rtl/rtc_irq_pkg.sv
// Shared definitions for the RTC tick and timer interrupt unit:
// write-port address codes and status-word bit positions.
package rtc_irq_pkg;

    typedef enum logic [2:0] {
        REG_TIME     = 3'd0,
        REG_MATCH    = 3'd1,
        REG_ACK_T1   = 3'd2,
        REG_ACK_T2   = 3'd3,
        REG_ACK_RTC  = 3'd4,
        REG_ACK_TICK = 3'd5
    } reg_addr_e;

    localparam int NUM_TIMERS = 2;
    localparam int FLAG_RTC   = 2;
    localparam int FLAG_TICK  = 3;
    localparam int NUM_FLAGS  = 4;

endpackage

// File: rtl/rtc_irq_flag.sv
// Latched interrupt flag.
// A set event wins over an acknowledge in the same cycle.
// hold_off forces the flag low and blocks setting.
// Assumes all inputs are single-cycle enables in the clk domain.
module rtc_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic ack,
    input  logic hold_off,
    output logic flag
);

    logic flag_q;

    // Flag register: set is sticky, ack clears, hold_off overrides both
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (hold_off) flag_q <= 1'b0;
        else if (set_ev)   flag_q <= 1'b1;
        else if (ack)      flag_q <= 1'b0;
    end

    assign flag = flag_q;

endmodule

// File: rtl/rtc_timer_arm.sv
// Arms a timer underflow flag.
// An underflow pulse records a pending event. The flag is set by the
// first timer-clock falling enable in a later cycle; an enable in the
// same cycle as the underflow is not counted.
// Assumes uflow and clk_fall are single-cycle enables in the clk domain.
module rtc_timer_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic uflow,
    input  logic clk_fall,
    input  logic ack,
    output logic flag
);

    logic pend_q;
    logic fire;

    // Pending register: a new underflow re-arms, a falling edge consumes
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (uflow)    pend_q <= 1'b1;
        else if (clk_fall) pend_q <= 1'b0;
    end

    // A falling edge while armed raises the flag
    assign fire = pend_q & clk_fall;

    rtc_irq_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (fire),
        .ack      (ack),
        .hold_off (1'b0),
        .flag     (flag)
    );

endmodule

// File: rtl/rtc_prescaler.sv
// Binary prescaler of STAGES ripple-equivalent stages, stepped by osc_en.
// It emits registered one-cycle pulses when the last stage rises
// (sec_tick) and when stage FAST_STAGE rises (fast_tick).
// clr resets all stages and suppresses the pulses of that cycle.
// Assumes osc_en is a single-cycle enable in the clk domain.
module rtc_prescaler #(
    parameter int STAGES     = 15,
    parameter int FAST_STAGE = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic clr,
    output logic sec_tick,
    output logic fast_tick
);

    localparam int SEC_BIT  = STAGES - 1;
    localparam int FAST_BIT = FAST_STAGE - 1;

    logic [STAGES-1:0] cnt_q;
    logic [STAGES-1:0] cnt_inc;
    logic [STAGES-1:0] stage_rise;
    logic              sec_q;
    logic              fast_q;

    assign cnt_inc = cnt_q + 1'b1;

    // Rising detection for every stage output on the next step
    for (genvar g = 0; g < STAGES; g++) begin : g_rise
        assign stage_rise[g] = osc_en & ~clr & cnt_inc[g] & ~cnt_q[g];
    end

    // Stage counter: cleared on time load, stepped per oscillator enable
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (osc_en) cnt_q <= cnt_inc;
    end

    // Edge pulse registers for the two tapped stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= 1'b0;
            fast_q <= 1'b0;
        end else begin
            sec_q  <= stage_rise[SEC_BIT];
            fast_q <= stage_rise[FAST_BIT];
        end
    end

    assign sec_tick  = sec_q;
    assign fast_tick = fast_q;

endmodule

// File: rtl/rtc_seconds_match.sv
// Seconds counter with a compare register.
// On each sec_tick the counter advances by one, wrapping at its width.
// match_hit pulses on a sec_tick whose pre-increment count equals the
// compare register, so a match is reported one second after it began.
// A time load has priority over a coincident tick.
module rtc_seconds_match #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             time_wr,
    input  logic             match_wr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] seconds,
    output logic             match_hit
);

    logic [WIDTH-1:0] sec_q;
    logic [WIDTH-1:0] cmp_q;

    // Seconds register: software load, else increment on tick
    always_ff @(posedge clk) begin
        if (!rst_n)        sec_q <= '0;
        else if (time_wr)  sec_q <= wr_data;
        else if (sec_tick) sec_q <= sec_q + 1'b1;
    end

    // Compare register: software load only
    always_ff @(posedge clk) begin
        if (!rst_n)        cmp_q <= '0;
        else if (match_wr) cmp_q <= wr_data;
    end

    assign match_hit = sec_tick & (sec_q == cmp_q);
    assign seconds   = sec_q;

endmodule

// File: rtl/rtc_irq_unit.sv
// RTC tick and timer interrupt unit (top).
// Combines the prescaler, the seconds/match logic, two timer arming
// channels and the tick flag, and decodes the write port.
// Assumes one clock domain; all edges arrive as single-cycle enables.
module rtc_irq_unit
    import rtc_irq_pkg::*;
#(
    parameter int PRESC_STAGES = 15,
    parameter int TICK_STAGE   = 9,
    parameter int SEC_W        = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  osc_en,
    input  logic                  standby,
    input  logic [NUM_TIMERS-1:0] tmr_uflow,
    input  logic [NUM_TIMERS-1:0] tmr_clk_fall,
    input  logic                  wr_en,
    input  logic [2:0]            wr_addr,
    input  logic [SEC_W-1:0]      wr_data,
    output logic [NUM_FLAGS-1:0]  irq_status,
    output logic [SEC_W-1:0]      rtc_seconds
);

    logic       time_wr;
    logic       match_wr;
    logic       ack_rtc;
    logic       ack_tick;
    logic       sec_tick;
    logic       fast_tick;
    logic       match_hit;
    logic [NUM_TIMERS-1:0] ack_tmr;
    logic [NUM_TIMERS-1:0] tmr_flag;
    logic       rtc_flag;
    logic       tick_flag;

    // Write decode: one strobe per register or acknowledge address
    assign time_wr  = wr_en & (wr_addr == REG_TIME);
    assign match_wr = wr_en & (wr_addr == REG_MATCH);
    assign ack_rtc  = wr_en & (wr_addr == REG_ACK_RTC);
    assign ack_tick = wr_en & (wr_addr == REG_ACK_TICK);

    rtc_prescaler #(
        .STAGES     (PRESC_STAGES),
        .FAST_STAGE (TICK_STAGE)
    ) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_en    (osc_en),
        .clr       (time_wr),
        .sec_tick  (sec_tick),
        .fast_tick (fast_tick)
    );

    rtc_seconds_match #(
        .WIDTH (SEC_W)
    ) u_secs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .time_wr   (time_wr),
        .match_wr  (match_wr),
        .wr_data   (wr_data),
        .seconds   (rtc_seconds),
        .match_hit (match_hit)
    );

    // One arming channel per timer; acknowledge addresses are consecutive
    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
        assign ack_tmr[t] = wr_en & (wr_addr == 3'(int'(REG_ACK_T1) + t));

        rtc_timer_arm u_arm (
            .clk      (clk),
            .rst_n    (rst_n),
            .uflow    (tmr_uflow[t]),
            .clk_fall (tmr_clk_fall[t]),
            .ack      (ack_tmr[t]),
            .flag     (tmr_flag[t])
        );
    end

    rtc_irq_flag u_rtc_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (match_hit),
        .ack      (ack_rtc),
        .hold_off (1'b0),
        .flag     (rtc_flag)
    );

    rtc_irq_flag u_tick_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (fast_tick),
        .ack      (ack_tick),
        .hold_off (standby),
        .flag     (tick_flag)
    );

    assign irq_status = {tick_flag, rtc_flag, tmr_flag};

endmodule

// File: rtl/rtc_irq_checker.sv
// Property checker for rtc_irq_unit, attached by bind.
module rtc_irq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        standby,
    input logic [1:0]  tmr_clk_fall,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [3:0]  irq_status,
    input logic [31:0] rtc_seconds
);

    for (genvar i = 0; i < 2; i++) begin : g_tmr_chk
        // R2: a timer flag only rises in the cycle after a falling-edge enable
        assert_tmr_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_status[i] && !$past(irq_status[i])) |-> $past(tmr_clk_fall[i]));

        // R3: acknowledge without a coincident edge clears the flag
        assert_tmr_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == 3'(2 + i) && !tmr_clk_fall[i]) |=> !irq_status[i]);

        // R3: without its acknowledge a set flag holds
        assert_tmr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_status[i] && !(wr_en && wr_addr == 3'(2 + i))) |=> irq_status[i]);
    end

    // R6: seconds move only by a load or a single increment
    assert_sec_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rtc_seconds) && !$past(wr_en && wr_addr == 3'd0))
            |-> rtc_seconds == $past(rtc_seconds) + 32'd1);

    // R9: standby keeps the tick flag low from the next cycle
    assert_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !irq_status[3]);

endmodule

bind rtc_irq_unit rtc_irq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .standby      (standby),
    .tmr_clk_fall (tmr_clk_fall),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .irq_status   (irq_status),
    .rtc_seconds  (rtc_seconds)
);

// File: tb/tb_rtc_irq_unit.sv
module tb_rtc_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_en = 1'b0;
    logic        standby = 1'b0;
    logic [1:0]  tmr_uflow = 2'b00;
    logic [1:0]  tmr_clk_fall = 2'b00;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic [3:0]  irq_status;
    logic [31:0] rtc_seconds;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rtc_irq_unit dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_en       (osc_en),
        .standby      (standby),
        .tmr_uflow    (tmr_uflow),
        .tmr_clk_fall (tmr_clk_fall),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .irq_status   (irq_status),
        .rtc_seconds  (rtc_seconds)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Timer model step: returns next {flag, pend} per channel
    function automatic logic [1:0] tmr_next(input logic flag, input logic pend,
                                           input logic uf, input logic fall, input logic ack);
        logic f_n, p_n;
        f_n = (pend & fall) | (flag & ~ack);
        p_n = uf | (pend & ~fall);
        return {f_n, p_n};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [1:0] flg, pnd;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_status == 4'b0, "R1 status", 32'(irq_status), 32'h0);
        chk(rtc_seconds == 32'd0, "R1 seconds", rtc_seconds, 32'h0);

        // Directed R2: edge in the underflow cycle is not counted
        tmr_uflow = 2'b01; tmr_clk_fall = 2'b01;
        @(negedge clk);
        tmr_uflow = 2'b00; tmr_clk_fall = 2'b00;
        @(negedge clk);
        chk(irq_status[0] == 1'b0, "R2 same-cycle edge", 32'(irq_status[0]), 32'h0);
        tmr_clk_fall = 2'b01;
        @(negedge clk);
        tmr_clk_fall = 2'b00;
        chk(irq_status[0] == 1'b1, "R2 later edge", 32'(irq_status[0]), 32'h1);
        // R3: wrong address and timer 2 ack leave timer 1 set
        wr(3'd3, 32'hFFFF_FFFF);
        chk(irq_status[0] == 1'b1, "R3 other ack", 32'(irq_status[0]), 32'h1);
        wr(3'd2, 32'h0);
        chk(irq_status[0] == 1'b0, "R3 own ack", 32'(irq_status[0]), 32'h0);
        // R4: ack colliding with set keeps the flag
        tmr_uflow = 2'b10;
        @(negedge clk);
        tmr_uflow = 2'b00; tmr_clk_fall = 2'b10;
        wr(3'd3, 32'h5A);
        tmr_clk_fall = 2'b00;
        chk(irq_status[1] == 1'b1, "R4 ack with set", 32'(irq_status[1]), 32'h1);
        wr(3'd3, 32'h0);
        chk(irq_status == 4'b0, "R10 layout clear", 32'(irq_status), 32'h0);

        // Random timer traffic against the model (R2, R3, R4)
        flg = 2'b00; pnd = 2'b00;
        for (int k = 0; k < 600; k++) begin
            logic [1:0] uf, fa, ak;
            logic [2:0] a;
            bit we;
            chk(irq_status[1:0] == flg, "R2/R3 random timers", 32'(irq_status[1:0]), 32'(flg));
            uf = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
            fa = 2'($urandom_range(0, 3));
            we = ($urandom_range(0, 3) == 0);
            a  = 3'($urandom_range(2, 7));
            if (a == 3'd4 || a == 3'd5) a = 3'd6;
            ak[0] = we && a == 3'd2;
            ak[1] = we && a == 3'd3;
            for (int t = 0; t < 2; t++) begin
                logic [1:0] r;
                r = tmr_next(flg[t], pnd[t], uf[t], fa[t], ak[t]);
                flg[t] = r[1]; pnd[t] = r[0];
            end
            tmr_uflow = uf; tmr_clk_fall = fa;
            wr_en = we; wr_addr = a; wr_data = $urandom;
            @(negedge clk);
        end
        tmr_uflow = 2'b00; tmr_clk_fall = 2'b00; wr_en = 1'b0;
        chk(irq_status[1:0] == flg, "R3 random end", 32'(irq_status[1:0]), 32'(flg));
        chk(rtc_seconds == 32'd0, "R10 addr 6/7 no effect", rtc_seconds, 32'h0);
        wr(3'd2, 0); wr(3'd3, 0);

        // R8: 64 Hz stage timing
        wr(3'd0, 32'd0);
        osc_en = 1'b1;
        edges(256);
        chk(irq_status[3] == 1'b0, "R8 before tick", 32'(irq_status[3]), 32'h0);
        edges(1);
        chk(irq_status[3] == 1'b1, "R8 tick set", 32'(irq_status[3]), 32'h1);
        osc_en = 1'b0;
        wr(3'd5, 32'h0);
        chk(irq_status[3] == 1'b0, "R8 tick ack", 32'(irq_status[3]), 32'h0);

        // R9: standby suppresses the tick
        standby = 1'b1; osc_en = 1'b1;
        begin
            bit seen = 1'b0;
            for (int k = 0; k < 1100; k++) begin
                @(negedge clk);
                if (irq_status[3]) seen = 1'b1;
            end
            chk(!seen, "R9 standby tick", 32'(seen), 32'h0);
        end
        osc_en = 1'b0; standby = 1'b0;
        @(negedge clk);

        // R5/R6/R7: load near wrap, match one second after equality
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'h0);
        wr(3'd4, 32'h0);
        osc_en = 1'b1;
        edges(16384);
        chk(rtc_seconds == 32'hFFFF_FFFF, "R5 before second", rtc_seconds, 32'hFFFF_FFFF);
        edges(1);
        chk(rtc_seconds == 32'h0, "R6 wrap", rtc_seconds, 32'h0);
        chk(irq_status[2] == 1'b0, "R7 not at equality", 32'(irq_status[2]), 32'h0);
        edges(32767);
        chk(rtc_seconds == 32'h0, "R5 period", rtc_seconds, 32'h0);
        chk(irq_status[2] == 1'b0, "R7 before next second", 32'(irq_status[2]), 32'h0);
        edges(1);
        chk(rtc_seconds == 32'h1, "R5 second increment", rtc_seconds, 32'h1);
        chk(irq_status[2] == 1'b1, "R7 match set", 32'(irq_status[2]), 32'h1);
        osc_en = 1'b0;
        wr(3'd7, 32'h0);
        chk(irq_status[2] == 1'b1, "R10 addr 7 ignored", 32'(irq_status[2]), 32'h1);
        wr(3'd4, 32'hABCD);
        chk(irq_status[2] == 1'b0, "R7 match ack", 32'(irq_status[2]), 32'h0);
        chk(rtc_seconds == 32'h1, "R6 held", rtc_seconds, 32'h1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule